// File: doc/BRIEF.md
# Page-Buffered Flash Sample Writer

This block records a stream of 12-bit samples into an 8-bit, page-programmed NAND-style flash. Each sample is written through one port of an on-chip dual-port buffer. A sequencer reads the samples back through the other port and turns each one into two flash bytes. The first byte holds the upper eight sample bits. The second byte holds a fixed flag nibble above the lowest four sample bits. Because the buffer sits between the two sides, acquisition carries on while the flash is busy with command bytes, address bytes or its internal program time.

A recording session begins with a pulse on `start`. The block first erases one block: an erase opcode, the row address of page 0, and an erase-confirm opcode. It then waits for the flash to go busy and to come ready again. After that it fills pages one at a time. For each page it sends a program opcode, the column bytes (always zero), the row bytes of the current page index, exactly one page of data bytes, and a program-confirm opcode. It then polls the ready line before opening the next page. Every byte goes out with its own write strobe. The setup time and the strobe low time are parameters, counted in clock cycles.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `fl_we_n` is 1, `fl_cle`, `fl_ale` and `overflow` are 0, and no write strobe occurs until `start` is pulsed.
- R2: Samples presented before `start` are discarded and never reach the flash.
- R3: On `start` the block sends 0x60 with `fl_cle`=1, then ROW_BYTES zero bytes with `fl_ale`=1, then 0xD0 with `fl_cle`=1.
- R4: Each page is sent as 0x80 (cle), then COL_BYTES zero bytes (ale), then ROW_BYTES bytes of the page index least significant byte first (ale), then PAGE_BYTES data bytes (cle=ale=0), then 0x10 (cle).
- R5: A sample s becomes the data byte s[11:4] followed by the data byte {FLAG, s[3:0]}, and samples appear in the order they arrived.
- R6: The page index is 0 for the first page after an erase and rises by one after each page-confirm opcode.
- R7: After 0xD0 or 0x10, no write strobe is issued until `fl_rdy` has been seen low and then high.
- R8: For every byte, `fl_io`, `fl_cle` and `fl_ale` hold steady for SETUP_CYC cycles before `fl_we_n` falls. `fl_we_n` stays low for exactly PULSE_CYC cycles, and the bus holds one more cycle after `fl_we_n` rises.
- R9: Up to DEPTH samples that arrive back to back while the flash is busy or receiving command and address bytes are all kept and later written.
- R10: A sample that arrives while DEPTH unread samples are held is dropped, and `overflow` goes to 1 and stays at 1.
- R11: `fl_cle` and `fl_ale` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a session: erase, then recording |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample value |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_io | output | 8 | Flash data bus |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The case that is hardest to reach from the ports is a buffer that fills to exactly its depth while the read side is stalled, without a single sample being lost. The bench waits until it sees a given page-confirm opcode on the bus. It then sends DEPTH samples on consecutive cycles inside the modelled busy window, so every one of them lands in the buffer before the first read. The bench then checks that the byte stream carries all of them and that `overflow` is still 0. A second, longer burst then goes past the depth to force the overflow condition.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
   localparam int SMP_W = 12;

   localparam logic [7:0] OP_ERASE    = 8'h60;
   localparam logic [7:0] OP_ERASE_GO = 8'hD0;
   localparam logic [7:0] OP_PROG     = 8'h80;
   localparam logic [7:0] OP_PROG_GO  = 8'h10;

   typedef enum logic [1:0] {BK_DATA, BK_CMD, BK_ADDR} bus_kind_e;

   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} strobe_ph_e;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_ERASE_CMD, SQ_ERASE_ADR, SQ_ERASE_GO, SQ_WAIT_BUSY,
      SQ_WAIT_RDY, SQ_WAIT_DATA, SQ_PROG_ADR, SQ_FETCH, SQ_HI, SQ_LO,
      SQ_PROG_GO
   } seq_st_e;
endpackage

// File: rtl/fpw_sample_buffer.sv
module fpw_sample_buffer #(
   parameter int W     = 12,
   parameter int DEPTH = 512
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         overflow
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("fpw_sample_buffer: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         full;

   // one extra pointer bit tells a full buffer apart from an empty one
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign empty = (wp == rp);

   // port A: acquisition side
   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         rd_data  <= '0;
         overflow <= 1'b0;
      end else if (restart) begin
         wp       <= '0;
         rp       <= '0;
         overflow <= 1'b0;
      end else begin
         if (wr_en && !full) wp <= wp + 1'b1;
         if (wr_en && full)  overflow <= 1'b1;
         // port B: flash side, registered read
         if (rd_en && !empty) begin
            rd_data <= mem[rp[AW-1:0]];
            rp      <= rp + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpw_bus_strobe.sv
module fpw_bus_strobe
   import fpw_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int PULSE_CYC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  bus_kind_e  kind,
   input  logic [7:0] byte_in,
   output logic       idle,
   output logic       we_n,
   output logic       cle,
   output logic       ale,
   output logic [7:0] io
);
   localparam int LONGEST = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
   localparam int CW      = $clog2(LONGEST + 1);

   if (SETUP_CYC < 1 || PULSE_CYC < 1) begin : g_bad_timing
      $error("fpw_bus_strobe: SETUP_CYC and PULSE_CYC must be at least 1");
   end

   strobe_ph_e    ph;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
         io  <= '0;
         cle <= 1'b0;
         ale <= 1'b0;
      end else begin
         case (ph)
            PH_IDLE: if (req) begin
               ph  <= PH_SETUP;
               cnt <= '0;
               io  <= byte_in;
               cle <= (kind == BK_CMD);
               ale <= (kind == BK_ADDR);
            end
            PH_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
               ph  <= PH_LOW;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
            PH_LOW: if (cnt == CW'(PULSE_CYC - 1)) begin
               ph <= PH_HOLD;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: begin
               ph  <= PH_IDLE;
               cle <= 1'b0;
               ale <= 1'b0;
            end
         endcase
      end
   end

   assign we_n = (ph != PH_LOW);
   assign idle = (ph == PH_IDLE);
endmodule

// File: rtl/fpw_sequencer.sv
module fpw_sequencer
   import fpw_pkg::*;
#(
   parameter int         PAGE_BYTES = 512,
   parameter int         COL_BYTES  = 2,
   parameter int         ROW_BYTES  = 2,
   parameter logic [3:0] FLAG       = 4'hA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fl_rdy,
   input  logic             buf_empty,
   input  logic [SMP_W-1:0] smp,
   input  logic             st_idle,
   output logic             buf_rd,
   output logic             st_req,
   output bus_kind_e        st_kind,
   output logic [7:0]       st_byte,
   output logic             active,
   output logic             restart
);
   localparam int AB = COL_BYTES + ROW_BYTES;
   localparam int IW = $clog2(AB + 1);
   localparam int BW = $clog2(PAGE_BYTES + 1);
   localparam int PW = 8 * ROW_BYTES;

   if (PAGE_BYTES < 2 || (PAGE_BYTES % 2) != 0 || ROW_BYTES < 1 || COL_BYTES < 0)
   begin : g_bad_geom
      $error("fpw_sequencer: PAGE_BYTES must be even and ROW_BYTES at least 1");
   end

   seq_st_e       st, nxt;
   logic [IW-1:0] idx;
   logic [BW-1:0] bcnt;
   logic [PW-1:0] page_q;
   logic [7:0]    row_b [ROW_BYTES];
   logic [7:0]    adr_b;
   logic          idx_col, idx_zero, idx_inc, bcnt_add, bcnt_clr, page_inc;

   for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
      assign row_b[g] = page_q[g*8 +: 8];
   end

   // column bytes are zero, row bytes carry the page index low byte first
   always_comb begin
      adr_b = 8'h00;
      for (int k = 0; k < ROW_BYTES; k++) begin
         if (idx == IW'(COL_BYTES + k)) adr_b = row_b[k];
      end
   end

   always_comb begin
      nxt      = st;
      st_req   = 1'b0;
      st_kind  = BK_CMD;
      st_byte  = 8'h00;
      buf_rd   = 1'b0;
      idx_col  = 1'b0;
      idx_zero = 1'b0;
      idx_inc  = 1'b0;
      bcnt_add = 1'b0;
      bcnt_clr = 1'b0;
      page_inc = 1'b0;
      case (st)
         SQ_IDLE: if (start) begin
            nxt     = SQ_ERASE_CMD;
            idx_col = 1'b1;
         end
         SQ_ERASE_CMD: if (st_idle) begin
            st_req  = 1'b1;
            st_byte = OP_ERASE;
            nxt     = SQ_ERASE_ADR;
         end
         SQ_ERASE_ADR, SQ_PROG_ADR: if (st_idle) begin
            st_req  = 1'b1;
            st_kind = BK_ADDR;
            st_byte = adr_b;
            idx_inc = 1'b1;
            if (idx == IW'(AB - 1))
               nxt = (st == SQ_ERASE_ADR) ? SQ_ERASE_GO : SQ_FETCH;
         end
         SQ_ERASE_GO: if (st_idle) begin
            st_req  = 1'b1;
            st_byte = OP_ERASE_GO;
            nxt     = SQ_WAIT_BUSY;
         end
         SQ_WAIT_BUSY: if (st_idle && !fl_rdy) nxt = SQ_WAIT_RDY;
         SQ_WAIT_RDY:  if (fl_rdy) nxt = SQ_WAIT_DATA;
         SQ_WAIT_DATA: if (st_idle && !buf_empty) begin
            st_req   = 1'b1;
            st_byte  = OP_PROG;
            idx_zero = 1'b1;
            nxt      = SQ_PROG_ADR;
         end
         SQ_FETCH: if (st_idle && !buf_empty) begin
            buf_rd = 1'b1;
            nxt    = SQ_HI;
         end
         SQ_HI: if (st_idle) begin
            st_req  = 1'b1;
            st_kind = BK_DATA;
            st_byte = smp[11:4];
            nxt     = SQ_LO;
         end
         SQ_LO: if (st_idle) begin
            st_req  = 1'b1;
            st_kind = BK_DATA;
            st_byte = {FLAG, smp[3:0]};
            if (bcnt == BW'(PAGE_BYTES - 2)) begin
               bcnt_clr = 1'b1;
               nxt      = SQ_PROG_GO;
            end else begin
               bcnt_add = 1'b1;
               nxt      = SQ_FETCH;
            end
         end
         SQ_PROG_GO: if (st_idle) begin
            st_req   = 1'b1;
            st_byte  = OP_PROG_GO;
            page_inc = 1'b1;
            nxt      = SQ_WAIT_BUSY;
         end
         default: nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         idx    <= '0;
         bcnt   <= '0;
         page_q <= '0;
      end else begin
         st <= nxt;
         if (restart)       page_q <= '0;
         else if (page_inc) page_q <= page_q + 1'b1;
         if (idx_col)       idx <= IW'(COL_BYTES);
         else if (idx_zero) idx <= '0;
         else if (idx_inc)  idx <= idx + 1'b1;
         if (restart || bcnt_clr) bcnt <= '0;
         else if (bcnt_add)       bcnt <= bcnt + BW'(2);
      end
   end

   assign active  = (st != SQ_IDLE);
   assign restart = (st == SQ_IDLE) && start;
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
   import fpw_pkg::*;
#(
   parameter int         PAGE_BYTES = 512,
   parameter int         DEPTH      = 512,
   parameter int         COL_BYTES  = 2,
   parameter int         ROW_BYTES  = 2,
   parameter int         SETUP_CYC  = 1,
   parameter int         PULSE_CYC  = 1,
   parameter logic [3:0] FLAG       = 4'hA
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        smp_valid,
   input  logic [11:0] smp_data,
   input  logic        fl_rdy,
   output logic        fl_cle,
   output logic        fl_ale,
   output logic        fl_we_n,
   output logic [7:0]  fl_io,
   output logic        overflow
);
   logic             active, restart, buf_empty, buf_rd, st_idle, st_req;
   logic [SMP_W-1:0] rd_smp;
   bus_kind_e        st_kind;
   logic [7:0]       st_byte;

   fpw_sample_buffer #(.W(SMP_W), .DEPTH(DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .wr_en    (smp_valid && active),
      .wr_data  (smp_data),
      .rd_en    (buf_rd),
      .rd_data  (rd_smp),
      .empty    (buf_empty),
      .overflow (overflow)
   );

   fpw_sequencer #(
      .PAGE_BYTES (PAGE_BYTES),
      .COL_BYTES  (COL_BYTES),
      .ROW_BYTES  (ROW_BYTES),
      .FLAG       (FLAG)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .fl_rdy    (fl_rdy),
      .buf_empty (buf_empty),
      .smp       (rd_smp),
      .st_idle   (st_idle),
      .buf_rd    (buf_rd),
      .st_req    (st_req),
      .st_kind   (st_kind),
      .st_byte   (st_byte),
      .active    (active),
      .restart   (restart)
   );

   fpw_bus_strobe #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_stb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (st_req),
      .kind    (st_kind),
      .byte_in (st_byte),
      .idle    (st_idle),
      .we_n    (fl_we_n),
      .cle     (fl_cle),
      .ale     (fl_ale),
      .io      (fl_io)
   );
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       fl_rdy,
   input logic       fl_cle,
   input logic       fl_ale,
   input logic       fl_we_n,
   input logic [7:0] fl_io,
   input logic       overflow
);
   a_r8_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> $stable(fl_io) && $stable(fl_cle) && $stable(fl_ale));

   a_r8_low_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_io) && $stable(fl_cle) && $stable(fl_ale));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> $stable(fl_io) && $stable(fl_cle) && $stable(fl_ale));

   a_r7_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_rdy |-> fl_we_n);

   a_r11_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_cle && fl_ale));

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

bind flash_page_writer fpw_checker u_fpw_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fl_rdy   (fl_rdy),
   .fl_cle   (fl_cle),
   .fl_ale   (fl_ale),
   .fl_we_n  (fl_we_n),
   .fl_io    (fl_io),
   .overflow (overflow)
);

// File: tb/test_flash_page_writer.sv
`timescale 1ns/1ps
module test_flash_page_writer;
   localparam int PB = 8, DP = 8, CB = 1, RB = 2, SU = 2, PL = 2, BUSY = 20;
   localparam logic [3:0] FL = 4'hA;
   localparam int PAGES = 8;
   localparam int PER_PAGE = 1 + CB + RB + PB + 1;
   localparam int TOTAL = 2 + RB + PAGES * PER_PAGE;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic fl_rdy, fl_cle, fl_ale, fl_we_n, overflow;
   logic [7:0] fl_io;

   int checks = 0, failures = 0;
   int nlog = 0, conf_cnt = 0, busy_cnt = 0, busy_viol = 0, low_run = 0;
   logic prev_we = 1'b1;
   logic [7:0] logb [256];
   int logk [256];
   int logw [256];
   logic [7:0] expb [256];
   int expk [256];

   always #2.5 clk = ~clk;
   assign fl_rdy = (busy_cnt == 0);

   flash_page_writer #(.PAGE_BYTES(PB), .DEPTH(DP), .COL_BYTES(CB), .ROW_BYTES(RB),
      .SETUP_CYC(SU), .PULSE_CYC(PL), .FLAG(FL)) i_flash_page_writer (
      .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
      .smp_data(smp_data), .fl_rdy(fl_rdy), .fl_cle(fl_cle), .fl_ale(fl_ale),
      .fl_we_n(fl_we_n), .fl_io(fl_io), .overflow(overflow));

   // flash model: log each byte at the rising strobe, go busy after confirms
   always @(negedge clk) begin
      if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
      if (prev_we && !fl_we_n && !fl_rdy) busy_viol = busy_viol + 1;
      if (!fl_we_n) low_run = low_run + 1;
      if (!prev_we && fl_we_n && nlog < 256) begin
         logb[nlog] = fl_io;
         logk[nlog] = fl_cle ? 1 : (fl_ale ? 2 : 0);
         logw[nlog] = low_run;
         nlog = nlog + 1;
         low_run = 0;
         if (fl_cle && (fl_io == 8'h10 || fl_io == 8'hD0)) busy_cnt = BUSY;
         if (fl_cle && fl_io == 8'h10) conf_cnt = conf_cnt + 1;
      end
      prev_we = fl_we_n;
   end

   function automatic logic [11:0] smp_val(int i);
      return 12'((i * 12'h29B + 12'h05C) & 12'hFFF);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic build_expected();
      int n = 0;
      expb[n] = 8'h60; expk[n] = 1; n++;                       // R3
      for (int r = 0; r < RB; r++) begin expb[n] = 8'h00; expk[n] = 2; n++; end
      expb[n] = 8'hD0; expk[n] = 1; n++;
      for (int p = 0; p < PAGES; p++) begin                     // R4, R6
         expb[n] = 8'h80; expk[n] = 1; n++;
         for (int c = 0; c < CB; c++) begin expb[n] = 8'h00; expk[n] = 2; n++; end
         for (int r = 0; r < RB; r++) begin
            expb[n] = 8'((p >> (8 * r)) & 255); expk[n] = 2; n++;
         end
         for (int s = 0; s < PB / 2; s++) begin                 // R5
            logic [11:0] v = smp_val(p * (PB / 2) + s);
            expb[n] = v[11:4];      expk[n] = 0; n++;
            expb[n] = {FL, v[3:0]}; expk[n] = 0; n++;
         end
         expb[n] = 8'h10; expk[n] = 1; n++;
      end
   endtask

   task automatic burst(input int first, input int cnt);
      for (int i = 0; i < cnt; i++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_data  = smp_val(first + i);
      end
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   initial begin
      #500000;
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", nlog, TOTAL);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      build_expected();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fl_we_n == 1'b1, "R1 we_n", fl_we_n, 1);
      chk(fl_cle == 1'b0 && fl_ale == 1'b0, "R1 cle/ale", {fl_cle, fl_ale}, 0);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);

      // R2: samples before start must be discarded
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); smp_valid = 1'b1; smp_data = 12'hFFF;
      end
      @(negedge clk); smp_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(nlog == 0, "R1 no strobe before start", nlog, 0);

      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;

      // six pages at a slow rate
      for (int i = 0; i < 24; i++) begin
         burst(i, 1);
         repeat (30) @(negedge clk);
      end
      // R9: fill the buffer to DEPTH while the flash is busy after page 6
      while (conf_cnt < 6) @(negedge clk);
      burst(24, DP);
      chk(overflow == 1'b0, "R9 no overflow at depth", overflow, 0);
      repeat (1500) @(negedge clk);

      chk(nlog == TOTAL, "R2 R4 byte count", nlog, TOTAL);
      for (int n = 0; n < TOTAL; n++) begin
         chk(logb[n] == expb[n], "R3 R4 R5 R6 R9 byte", logb[n], expb[n]);
         chk(logk[n] == expk[n], "R3 R4 R11 latch kind", logk[n], expk[n]);
         chk(logw[n] == PL, "R8 strobe low width", logw[n], PL);
      end
      chk(busy_viol == 0, "R7 strobe while busy", busy_viol, 0);
      chk(overflow == 1'b0, "R10 no false overflow", overflow, 0);

      // R10: push past the depth on consecutive cycles
      burst(100, DP + 4);
      chk(overflow == 1'b1, "R10 overflow set", overflow, 1);
      repeat (300) @(negedge clk);
      chk(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
      chk(busy_viol == 0, "R7 strobe while busy late", busy_viol, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule